// File: doc/BRIEF.md
# Six-State Range Counter

This block is a synchronous binary counter with clear, parallel load and count-enable controls and a carry output. A small feedback controller sits next to it and uses the same clear and load controls to keep the count inside a six-value window. A two-bit mode input, which may change while the block runs, picks one of four windows. Two windows start at zero: one reloads zero at the terminal count and the other clears at that count. A third window covers the top six codes and restarts from carry. A fourth covers three through eight and reloads three.

The external clear, load and count controls work in every mode. Feedback acts only on cycles with counting enabled. All changes take place on the rising clock edge.

Top module: `span6_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `count` becomes 0. Directly after reset `carry` reads 0 when `cnt_en` is 0.
- R2: With `clr` high, the next `count` is 0, whatever `ld`, `din`, `cnt_en` and `mode` are.
- R3: With `clr` low and `ld` high, the next `count` equals `din`, whether or not `cnt_en` is high.
- R4: With `clr` and `ld` low, `cnt_en` high moves `count` up by one, modulo 16, unless a mode terminal value applies. With `cnt_en` low, `count` holds and `din` has no effect.
- R5: `carry` is high exactly when `count` is 15 and `cnt_en` is high, in the same cycle.
- R6: Mode 2'b00: counting at 5 loads zero on the next edge, so the sequence is 0,1,2,3,4,5,0.
- R7: Mode 2'b01: counting at 5 clears the counter to 0 on the next edge, and `din` has no effect on that step.
- R8: Mode 2'b10: counting at 15 raises `carry`, which loads 10, so the sequence is 10,11,12,13,14,15,10.
- R9: Mode 2'b11: counting at 8 loads 3 on the next edge, so the sequence is 3,4,5,6,7,8,3.
- R10: Feedback acts only while `cnt_en` is high. With `cnt_en` low, a terminal value holds.
- R11: Start from any value outside the selected window and count continuously. Within 16 edges `count` is inside the window and stays there.
- R12: An external load wins over the feedback load in modes 2'b00, 2'b10 and 2'b11. In mode 2'b01 the feedback clear at 5 wins over an external load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Window select: 00 zero-load, 01 clear, 10 top window, 11 three-to-eight |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Parallel load request |
| clr | input | 1 | Synchronous clear request |
| din | input | 4 | Parallel load value |
| count | output | 4 | Counter state |
| carry | output | 1 | High at count 15 while counting is enabled |

## Verification
The collision that matters here is an external load or clear arriving on the same edge where the feedback controller wants to reload or clear the counter at a window end. The bench provokes it at count 5 in the clear mode, at 15 in the top window and at 8 in the three-to-eight window, each time with a load value unlike the feedback value. A reference model with the stated priority predicts the next count, and the scoreboard compares that prediction against the count seen after the edge. A clear issued together with load and count is judged the same way.

// File: rtl/span6_pkg.sv
package span6_pkg;

   typedef enum logic [1:0] {
      RM_ZERO_LOAD    = 2'b00,
      RM_ZERO_CLEAR   = 2'b01,
      RM_CARRY_RELOAD = 2'b10,
      RM_SHIFTED      = 2'b11
   } range_mode_e;

   typedef struct packed {
      logic clr;
      logic ld;
   } ctl_req_t;

endpackage

// File: rtl/span6_core.sv
module span6_core #(
   parameter int WIDTH      = 4,
   parameter int STEP_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic             cnt,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             co
);

   logic [WIDTH-1:0] inc_val;
   logic             at_top;
   logic [WIDTH-1:0] q_nxt;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("span6_core: WIDTH must be at least 2");
      end
      if (STEP_STYLE == 0) begin : g_adder
         assign inc_val = q + WIDTH'(1);
         assign at_top  = &q;
      end else begin : g_toggle
         logic [WIDTH:0] tch;
         assign tch[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign tch[i+1]   = tch[i] & q[i];
            assign inc_val[i] = q[i] ^ tch[i];
         end
         assign at_top = tch[WIDTH];
      end
   endgenerate

   always_comb begin
      if (clr)      q_nxt = '0;
      else if (ld)  q_nxt = din;
      else if (cnt) q_nxt = inc_val;
      else          q_nxt = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   assign co = at_top & cnt;

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

   p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld) |=> (q == $past(din)));

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && cnt) |=> (q == $past(q) + WIDTH'(1)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && !cnt) |=> $stable(q));

   p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (co && !clr && !ld) |=> (q == '0));

endmodule

// File: rtl/span6_ctrl.sv
module span6_ctrl
   import span6_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SPAN        = 6,
   parameter int OFFSET_BASE = 3
) (
   input  range_mode_e      mode,
   input  logic [WIDTH-1:0] q,
   input  logic             co,
   input  logic             cnt,
   output ctl_req_t         fb,
   output logic [WIDTH-1:0] fb_val
);

   localparam int FULL = 2 ** WIDTH;
   localparam logic [WIDTH-1:0] LOW_END    = WIDTH'(SPAN - 1);
   localparam logic [WIDTH-1:0] HIGH_BASE  = WIDTH'(FULL - SPAN);
   localparam logic [WIDTH-1:0] SHIFT_BASE = WIDTH'(OFFSET_BASE);
   localparam logic [WIDTH-1:0] SHIFT_END  = WIDTH'(OFFSET_BASE + SPAN - 1);

   generate
      if (SPAN < 2 || SPAN > FULL) begin : g_bad_span
         $error("span6_ctrl: SPAN out of range for WIDTH");
      end
      if (OFFSET_BASE < 0 || OFFSET_BASE + SPAN > FULL) begin : g_bad_offset
         $error("span6_ctrl: shifted window does not fit");
      end
   endgenerate

   logic low_hit;
   logic shift_hit;

   assign low_hit   = cnt && (q == LOW_END);
   assign shift_hit = cnt && (q == SHIFT_END);

   always_comb begin
      fb     = '0;
      fb_val = '0;
      unique case (mode)
         RM_ZERO_LOAD: begin
            fb.ld  = low_hit;
            fb_val = '0;
         end
         RM_ZERO_CLEAR: begin
            fb.clr = low_hit;
         end
         RM_CARRY_RELOAD: begin
            fb.ld  = co;
            fb_val = HIGH_BASE;
         end
         RM_SHIFTED: begin
            fb.ld  = shift_hit;
            fb_val = SHIFT_BASE;
         end
         default: begin
            fb     = '0;
            fb_val = '0;
         end
      endcase
   end

endmodule

// File: rtl/span6_arb.sv
module span6_arb
   import span6_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             ext_clr,
   input  logic             ext_ld,
   input  logic [WIDTH-1:0] ext_val,
   input  ctl_req_t         fb,
   input  logic [WIDTH-1:0] fb_val,
   output logic             core_clr,
   output logic             core_ld,
   output logic [WIDTH-1:0] core_val
);

   assign core_clr = ext_clr | fb.clr;
   assign core_ld  = ext_ld | fb.ld;
   assign core_val = ext_ld ? ext_val : fb_val;

endmodule

// File: rtl/span6_counter.sv
module span6_counter
   import span6_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SPAN        = 6,
   parameter int OFFSET_BASE = 3,
   parameter int STEP_STYLE  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             cnt_en,
   input  logic             ld,
   input  logic             clr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count,
   output logic             carry
);

   localparam int FULL = 2 ** WIDTH;
   localparam logic [WIDTH-1:0] LOW_END   = WIDTH'(SPAN - 1);
   localparam logic [WIDTH-1:0] HIGH_BASE = WIDTH'(FULL - SPAN);
   localparam logic [WIDTH-1:0] SHIFT_BASE = WIDTH'(OFFSET_BASE);
   localparam logic [WIDTH-1:0] SHIFT_END = WIDTH'(OFFSET_BASE + SPAN - 1);

   generate
      if (STEP_STYLE < 0 || STEP_STYLE > 1) begin : g_bad_style
         $error("span6_counter: STEP_STYLE must be 0 or 1");
      end
   endgenerate

   ctl_req_t         fb;
   logic [WIDTH-1:0] fb_val;
   logic             core_clr;
   logic             core_ld;
   logic [WIDTH-1:0] core_val;

   span6_ctrl #(
      .WIDTH       (WIDTH),
      .SPAN        (SPAN),
      .OFFSET_BASE (OFFSET_BASE)
   ) u_ctrl (
      .mode   (range_mode_e'(mode)),
      .q      (count),
      .co     (carry),
      .cnt    (cnt_en),
      .fb     (fb),
      .fb_val (fb_val)
   );

   span6_arb #(.WIDTH(WIDTH)) u_arb (
      .ext_clr  (clr),
      .ext_ld   (ld),
      .ext_val  (din),
      .fb       (fb),
      .fb_val   (fb_val),
      .core_clr (core_clr),
      .core_ld  (core_ld),
      .core_val (core_val)
   );

   span6_core #(
      .WIDTH      (WIDTH),
      .STEP_STYLE (STEP_STYLE)
   ) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (core_clr),
      .ld    (core_ld),
      .cnt   (cnt_en),
      .din   (core_val),
      .q     (count),
      .co    (carry)
   );

   p_low_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00 || mode == 2'b01) && cnt_en && !clr && !ld && count == LOW_END)
      |=> (count == '0));

   p_clear_beats_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && cnt_en && count == LOW_END) |=> (count == '0));

   p_top_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && carry && !clr && !ld) |=> (count == HIGH_BASE));

   p_shift_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && cnt_en && !clr && !ld && count == SHIFT_END)
      |=> (count == SHIFT_BASE));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !clr && !ld) |=> $stable(count));

   p_ext_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr && !(mode == 2'b01 && cnt_en && count == LOW_END))
      |=> (count == $past(din)));

endmodule

// File: tb/sim_span6_counter.sv
module sim_span6_counter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       cnt_en = 1'b0;
   logic       ld = 1'b0;
   logic       clr = 1'b0;
   logic [3:0] din = 4'd0;
   logic [3:0] count;
   logic       carry;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [3:0] m_q = 4'd0;
   logic [3:0] q_exp[$];
   string      q_tag[$];

   always #10 clk = ~clk;

   span6_counter u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_en(cnt_en),
      .ld(ld), .clr(clr), .din(din), .count(count), .carry(carry)
   );

   function automatic logic [3:0] model_next(logic [1:0] m, logic [3:0] q,
                                             logic en, logic l, logic c, logic [3:0] d);
      if (c) return 4'd0;
      if (en && m == 2'b01 && q == 4'd5) return 4'd0;
      if (l) return d;
      if (!en) return q;
      case (m)
         2'b00, 2'b01: return (q == 4'd5) ? 4'd0 : q + 4'd1;
         2'b10:        return (q == 4'd15) ? 4'd10 : q + 4'd1;
         default:      return (q == 4'd8) ? 4'd3 : q + 4'd1;
      endcase
   endfunction

   task automatic compare(string tag, logic [3:0] act, logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(logic [1:0] m, logic en, logic l, logic c, logic [3:0] d, string tag);
      @(negedge clk);
      mode = m; cnt_en = en; ld = l; clr = c; din = d;
      #1;
      compare("R5 carry", {3'b000, carry}, {3'b000, (m_q == 4'd15) && en});
      m_q = model_next(m, m_q, en, l, c, d);
      q_exp.push_back(m_q);
      q_tag.push_back(tag);
   endtask

   task automatic run(logic [1:0] m, int n, string tag);
      for (int i = 0; i < n; i++) step(m, 1'b1, 1'b0, 1'b0, 4'd0, tag);
   endtask

   task automatic check_window(logic [3:0] lo, logic [3:0] hi);
      @(negedge clk);
      cnt_en = 1'b0; ld = 1'b0; clr = 1'b0;
      #1;
      n_cmp++;
      if (count < lo || count > hi) begin
         n_bad++;
         $display("FAIL R11: actual %0d expected within %0d..%0d", count, lo, hi);
      end
   endtask

   initial begin : monitor
      logic [3:0] e;
      string t;
      forever begin
         @(posedge clk);
         #2;
         if (q_exp.size() != 0) begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            compare(t, count, e);
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare("R1 count", count, 4'd0);
      compare("R1 carry", {3'b000, carry}, 4'd0);

      run(2'b00, 3, "R4");
      step(2'b00, 1'b0, 1'b0, 1'b0, 4'd9, "R4");
      step(2'b00, 1'b0, 1'b1, 1'b0, 4'd9, "R3");
      run(2'b00, 6, "R4");
      step(2'b00, 1'b0, 1'b0, 1'b0, 4'd0, "R5");
      run(2'b00, 1, "R5");
      run(2'b00, 12, "R6");

      run(2'b01, 4, "R7");
      step(2'b01, 1'b1, 1'b0, 1'b0, 4'd7, "R7");
      step(2'b01, 1'b1, 1'b0, 1'b0, 4'd11, "R7");
      run(2'b01, 5, "R7");
      step(2'b01, 1'b1, 1'b1, 1'b0, 4'd12, "R12");

      step(2'b10, 1'b0, 1'b1, 1'b0, 4'd10, "R3");
      run(2'b10, 14, "R8");
      run(2'b10, 3, "R8");
      step(2'b10, 1'b1, 1'b1, 1'b0, 4'd4, "R12");

      step(2'b11, 1'b0, 1'b1, 1'b0, 4'd3, "R3");
      run(2'b11, 13, "R9");
      run(2'b11, 4, "R9");
      step(2'b11, 1'b0, 1'b0, 1'b0, 4'd0, "R10");
      step(2'b11, 1'b0, 1'b0, 1'b0, 4'd0, "R10");
      step(2'b11, 1'b1, 1'b1, 1'b0, 4'd12, "R12");

      step(2'b00, 1'b0, 1'b1, 1'b0, 4'd5, "R3");
      step(2'b00, 1'b0, 1'b0, 1'b0, 4'd0, "R10");
      step(2'b00, 1'b0, 1'b0, 1'b0, 4'd0, "R10");
      step(2'b00, 1'b1, 1'b0, 1'b0, 4'd0, "R6");

      step(2'b00, 1'b0, 1'b1, 1'b0, 4'd9, "R3");
      step(2'b00, 1'b1, 1'b1, 1'b1, 4'd9, "R2");
      step(2'b11, 1'b1, 1'b1, 1'b0, 4'd7, "R3");
      step(2'b11, 1'b1, 1'b1, 1'b1, 4'd2, "R2");

      run(2'b11, 16, "R11");
      check_window(4'd3, 4'd8);
      step(2'b11, 1'b0, 1'b1, 1'b0, 4'd9, "R3");
      run(2'b11, 16, "R11");
      check_window(4'd3, 4'd8);
      step(2'b10, 1'b0, 1'b1, 1'b0, 4'd0, "R3");
      run(2'b10, 16, "R11");
      check_window(4'd10, 4'd15);
      step(2'b01, 1'b0, 1'b1, 1'b0, 4'd13, "R3");
      run(2'b01, 16, "R11");
      check_window(4'd0, 4'd5);

      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule